// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the sequencing core of one DMA channel. Software programs it with a single packed control word, a pair of start addresses and a word count. When a control write is accepted, the channel steps through the transfer one word at a time. Each word is presented to the memory side as a read address and a write address under a valid/ready handshake. After each accepted word, both current addresses advance by the programmed word size and the remaining count drops by one. When the count runs out, a sticky done flag is set and an optional one-cycle interrupt pulse is sent.

The transfer kind sets how words are paced. Software kinds start at once, without waiting for any request. Hardware kinds wait for a rising edge on any request input that the request mask selects. Burst kinds move the whole block back to back. Single and arbitrated kinds move one word per grant and then release the bus. A non-zero priority field acts as the channel enable. A continue bit resumes from the addresses the last run left behind. A lock bit holds the bus lock output for the whole transfer, but only for non-burst kinds.

The memory side is a valid/ready stream and follows these back-pressure rules:
- While `mem_valid` is high and `mem_ready` is low, the channel holds the word. Valid, both addresses and the lock output stay unchanged.
- A word counts as moved only on a cycle where both valid and ready are high.

Top module: `dma_chan_seq`

## Requirements
- R1: A control write is accepted when the channel is idle and three conditions hold: bit 0 (run) is 1, the priority field [14:12] is non-zero, and the word is otherwise legal. An accepted write raises `busy` from the next cycle.
- R2: A control write whose priority field [14:12] is zero starts nothing: `busy` and `mem_valid` stay low.
- R3: The kind field [10:8] accepts only 000 (single), 001 (hardware-arbitrated), 101 (hardware-burst), 010 (software-arbitrated) and 110 (software-burst). Any other code, or any 1 in the unused bits [3:2], [7:6] or [31:29], starts nothing.
- R4: For software kinds (000, 010, 110), `mem_valid` is high in the cycle right after the accepting write.
- R5: Hardware kinds (001, 101) wait until a rising edge appears on a request input whose bit is set in the mask [28:16]. A request bit outside the mask has no effect. Each request input passes through two synchroniser flops before its edge is detected.
- R6: Burst kinds (bit 2 of the kind field set) keep `mem_valid` high from word to word while `mem_ready` is high. One hardware request moves the whole block.
- R7: Software single and arbitrated kinds drop `mem_valid` for exactly one cycle between words. The hardware-arbitrated kind needs a fresh request edge for each word.
- R8: After each accepted word, both addresses advance by the word size. The size field [5:4] gives 00 = 1 byte, 01 = 2 bytes, 10 or 11 = 4 bytes.
- R9: With the continue bit [15] at 0, a run starts from `start_src`/`start_dst`. With it at 1, the run resumes from the addresses the previous run left.
- R10: `bus_lock` is high through the whole transfer when the lock bit [11] is 1 and the kind is not a burst kind. A burst kind never asserts it.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, both addresses and `bus_lock` hold their values.
- R12: When the last word completes, `done` is set and stays set until the next accepted write clears it. `irq` pulses for one cycle only when bit 1 of the control word is 1. A count of zero completes at once and moves no words.
- R13: A control write made while the channel is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Packed control word |
| start_src | input | ADDR_W | Programmed source start address |
| start_dst | input | ADDR_W | Programmed destination start address |
| xfer_len | input | CNT_W | Number of words to move |
| hw_req | input | REQ_N | Asynchronous hardware request inputs |
| mem_valid | output | 1 | Word presented to memory side |
| mem_ready | input | 1 | Memory side accepts the word |
| mem_rd_addr | output | ADDR_W | Current source address |
| mem_wr_addr | output | ADDR_W | Current destination address |
| bus_lock | output | 1 | Bus lock for non-burst locked transfers |
| busy | output | 1 | Channel active |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest condition to reach from the ports is a control write that arrives while a hardware-arbitrated run is parked and waiting for a request. From outside, that write looks exactly like a fresh software start. The bench parks the channel by pulsing a request line that the mask leaves out, then writes a software-burst word while the channel waits. It then checks that no word appears until a selected request line rises, and that the words that follow use the first run's step and lock. The continue path is checked by running two transfers back to back, with the start addresses changed in between.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int CTRL_W     = 32;
  localparam int POS_RUN    = 0;
  localparam int POS_IRQEN  = 1;
  localparam int POS_SIZE   = 4;
  localparam int POS_KIND   = 8;
  localparam int POS_LOCK   = 11;
  localparam int POS_PRIO   = 12;
  localparam int POS_CONT   = 15;
  localparam int POS_MASK   = 16;
  localparam int STEP_W     = 3;

  typedef enum logic [2:0] {
    KIND_SINGLE   = 3'b000,
    KIND_HW_ARB   = 3'b001,
    KIND_SW_ARB   = 3'b010,
    KIND_HW_BURST = 3'b101,
    KIND_SW_BURST = 3'b110
  } xfer_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;

  function automatic logic [STEP_W-1:0] step_of(input logic [1:0] size);
    case (size)
      2'b00:   step_of = 3'd1;
      2'b01:   step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
  import dma_chan_pkg::*;
#(
  parameter int REQ_N = 13
) (
  input  logic [CTRL_W-1:0] word,
  output logic              run,
  output logic              irq_en,
  output logic              lock,
  output logic              cont,
  output logic              prio_on,
  output logic              legal,
  output logic              is_hw,
  output logic              is_burst,
  output logic [STEP_W-1:0] step,
  output logic [REQ_N-1:0]  mask
);

  localparam logic [CTRL_W-1:0] FIELD_BITS = 32'h0000_FF33;
  localparam logic [CTRL_W-1:0] MASK_BITS  =
    {{(CTRL_W-REQ_N){1'b0}}, {REQ_N{1'b1}}} << POS_MASK;
  localparam logic [CTRL_W-1:0] USED_BITS  = FIELD_BITS | MASK_BITS;

  logic [2:0] kind;
  logic       kind_ok;
  logic       spare_clear;

  assign run     = word[POS_RUN];
  assign irq_en  = word[POS_IRQEN];
  assign lock    = word[POS_LOCK];
  assign cont    = word[POS_CONT];
  assign prio_on = |word[POS_PRIO +: 3];
  assign kind    = word[POS_KIND +: 3];
  assign mask    = word[POS_MASK +: REQ_N];
  assign step    = step_of(word[POS_SIZE +: 2]);

  always_comb begin
    case (kind)
      KIND_SINGLE, KIND_HW_ARB, KIND_SW_ARB,
      KIND_HW_BURST, KIND_SW_BURST: kind_ok = 1'b1;
      default:                      kind_ok = 1'b0;
    endcase
  end

  assign spare_clear = ((word & ~USED_BITS) == '0);
  assign legal       = kind_ok & spare_clear;
  assign is_hw       = kind_ok & kind[0];
  assign is_burst    = kind_ok & kind[2];

endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect #(
  parameter int REQ_N  = 13,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_N-1:0] req_in,
  input  logic [REQ_N-1:0] mask,
  output logic             req_edge
);

  logic [REQ_N-1:0] rise;

  for (genvar i = 0; i < REQ_N; i++) begin : g_line
    logic [SYNC_N-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[SYNC_N-2:0], req_in[i]};
        prev  <= chain[SYNC_N-1];
      end
    end

    assign rise[i] = chain[SYNC_N-1] & ~prev;
  end

  assign req_edge = |(rise & mask);

endmodule

// File: rtl/dma_addr_count.sv
module dma_addr_count
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              resume,
  input  logic [ADDR_W-1:0] start_src,
  input  logic [ADDR_W-1:0] start_dst,
  input  logic [CNT_W-1:0]  len,
  input  logic              advance,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  remain,
  output logic              last
);

  logic [ADDR_W-1:0] step_ext;

  assign step_ext = {{(ADDR_W-STEP_W){1'b0}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src <= '0;
      cur_dst <= '0;
      remain  <= '0;
    end else if (load) begin
      if (!resume) begin
        cur_src <= start_src;
        cur_dst <= start_dst;
      end
      remain <= len;
    end else if (advance) begin
      cur_src <= cur_src + step_ext;
      cur_dst <= cur_dst + step_ext;
      remain  <= remain - 1'b1;
    end
  end

  assign last = (remain == {{(CNT_W-1){1'b0}}, 1'b1});

  AST_ADDR_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> ((cur_src - $past(cur_src)) == (cur_dst - $past(cur_dst)))); // R8

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_hw,
  input  logic             zero_len,
  input  logic             act_hw,
  input  logic             act_burst,
  input  logic             req_edge,
  input  logic             last,
  input  logic [CNT_W-1:0] remain,
  input  logic             mem_ready,
  output logic             mem_valid,
  output logic             busy,
  output logic             advance,
  output logic             complete
);

  seq_state_e st, st_nx;
  logic       pend;
  logic       trig;

  assign trig = pend | req_edge;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (start && !zero_len) st_nx = start_hw ? ST_WAIT : ST_XFER;
      ST_WAIT: if (trig) st_nx = ST_XFER;
      ST_XFER: begin
        if (mem_ready) begin
          if (last)           st_nx = ST_IDLE;
          else if (act_burst) st_nx = ST_XFER;
          else if (act_hw)    st_nx = ST_WAIT;
          else                st_nx = ST_GAP;
        end
      end
      default: st_nx = ST_XFER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      pend <= 1'b0;
    end else begin
      st <= st_nx;
      if (start)                     pend <= 1'b0;
      else if (st == ST_WAIT && trig) pend <= 1'b0;
      else if (req_edge && busy)     pend <= 1'b1;
    end
  end

  assign mem_valid = (st == ST_XFER);
  assign busy      = (st != ST_IDLE);
  assign advance   = mem_valid & mem_ready;
  assign complete  = (advance & last) | (start & zero_len);

  AST_BURST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && act_burst && !last) |=> mem_valid); // R6
  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (remain != '0)); // R12
  AST_SW_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |=> mem_valid); // R7

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REQ_N  = 13,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  input  logic [ADDR_W-1:0] start_src,
  input  logic [ADDR_W-1:0] start_dst,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic [REQ_N-1:0]  hw_req,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic              bus_lock,
  output logic              busy,
  output logic              done,
  output logic              irq
);

  logic              d_run, d_irq_en, d_lock, d_cont, d_prio_on, d_legal;
  logic              d_hw, d_burst;
  logic [STEP_W-1:0] d_step;
  logic [REQ_N-1:0]  d_mask;

  logic              act_irq_en, act_lock, act_hw, act_burst;
  logic [STEP_W-1:0] act_step;
  logic [REQ_N-1:0]  act_mask;

  logic              accept, zero_len, req_edge, last, advance, complete;
  logic [CNT_W-1:0]  remain;

  dma_ctrl_decode #(.REQ_N(REQ_N)) u_dec (
    .word     (ctrl_wdata),
    .run      (d_run),
    .irq_en   (d_irq_en),
    .lock     (d_lock),
    .cont     (d_cont),
    .prio_on  (d_prio_on),
    .legal    (d_legal),
    .is_hw    (d_hw),
    .is_burst (d_burst),
    .step     (d_step),
    .mask     (d_mask)
  );

  assign accept   = ctrl_wr & ~busy & d_run & d_prio_on & d_legal;
  assign zero_len = (xfer_len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_irq_en <= 1'b0;
      act_lock   <= 1'b0;
      act_hw     <= 1'b0;
      act_burst  <= 1'b0;
      act_step   <= '0;
      act_mask   <= '0;
    end else if (accept) begin
      act_irq_en <= d_irq_en;
      act_lock   <= d_lock;
      act_hw     <= d_hw;
      act_burst  <= d_burst;
      act_step   <= d_step;
      act_mask   <= d_mask;
    end
  end

  dma_req_detect #(.REQ_N(REQ_N), .SYNC_N(SYNC_N)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_in   (hw_req),
    .mask     (act_mask),
    .req_edge (req_edge)
  );

  dma_addr_count #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .resume    (d_cont),
    .start_src (start_src),
    .start_dst (start_dst),
    .len       (xfer_len),
    .advance   (advance),
    .step      (act_step),
    .cur_src   (mem_rd_addr),
    .cur_dst   (mem_wr_addr),
    .remain    (remain),
    .last      (last)
  );

  dma_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_hw  (d_hw),
    .zero_len  (zero_len),
    .act_hw    (act_hw),
    .act_burst (act_burst),
    .req_edge  (req_edge),
    .last      (last),
    .remain    (remain),
    .mem_ready (mem_ready),
    .mem_valid (mem_valid),
    .busy      (busy),
    .advance   (advance),
    .complete  (complete)
  );

  assign bus_lock = busy & act_lock & ~act_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (complete)    done <= 1'b1;
      else if (accept) done <= 1'b0;
      irq <= complete & (accept ? d_irq_en : act_irq_en);
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_rd_addr) &&
                                   $stable(mem_wr_addr) && $stable(bus_lock))); // R11
  AST_LOCK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_lock)); // R10
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R12
  AST_BUSY_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> $stable(mem_rd_addr) || $past(advance)); // R13

endmodule

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] start_src = '0;
  logic [31:0] start_dst = '0;
  logic [15:0] xfer_len = '0;
  logic [12:0] hw_req = '0;
  logic        mem_ready = 1'b0;
  logic        mem_valid, bus_lock, busy, done, irq;
  logic [31:0] mem_rd_addr, mem_wr_addr;

  int nchk = 0;
  int nfail = 0;
  int irq_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_chan_seq u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .start_src(start_src), .start_dst(start_dst), .xfer_len(xfer_len),
    .hw_req(hw_req), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_rd_addr(mem_rd_addr), .mem_wr_addr(mem_wr_addr),
    .bus_lock(bus_lock), .busy(busy), .done(done), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  function automatic logic [31:0] mk(input logic [12:0] mask, input logic cont,
                                     input logic [2:0] prio, input logic lck,
                                     input logic [2:0] kind, input logic [1:0] size,
                                     input logic ie);
    mk = {3'b000, mask, cont, prio, lck, kind, 2'b00, size, 2'b00, ie, 1'b1};
  endfunction

  typedef struct packed {
    logic [31:0] ctrl;
    logic [7:0]  len;
    logic [31:0] sa;
    logic [31:0] da;
    logic [3:0]  step;
    logic [1:0]  gap;
    logic        lck;
    logic [3:0]  hwb;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{mk(13'h0,    1'b0, 3'd1, 1'b1, 3'b000, 2'd2, 1'b1), 8'd3, 32'h0000_1000, 32'h0000_8000, 4'd4, 2'd1, 1'b1, 4'hF},
    '{mk(13'h0,    1'b0, 3'd3, 1'b0, 3'b010, 2'd1, 1'b0), 8'd4, 32'h0000_2000, 32'h0000_9000, 4'd2, 2'd1, 1'b0, 4'hF},
    '{mk(13'h0,    1'b0, 3'd7, 1'b1, 3'b110, 2'd0, 1'b1), 8'd5, 32'h0000_3001, 32'h0000_A003, 4'd1, 2'd0, 1'b0, 4'hF},
    '{mk(13'h0080, 1'b0, 3'd2, 1'b1, 3'b101, 2'd2, 1'b0), 8'd4, 32'h0000_4000, 32'h0000_B000, 4'd4, 2'd0, 1'b0, 4'd7},
    '{mk(13'h0,    1'b0, 3'd4, 1'b0, 3'b110, 2'd3, 1'b0), 8'd2, 32'h0000_5000, 32'h0000_C000, 4'd4, 2'd0, 1'b0, 4'hF},
    '{mk(13'h0,    1'b0, 3'd5, 1'b1, 3'b010, 2'd0, 1'b0), 8'd2, 32'h0000_6000, 32'h0000_D000, 4'd1, 2'd1, 1'b1, 4'hF}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  task automatic write_ctrl(input logic [31:0] w, input logic [31:0] sa,
                            input logic [31:0] da, input logic [15:0] n);
    @(negedge clk);
    ctrl_wdata = w; start_src = sa; start_dst = da; xfer_len = n; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic pulse(input int b);
    @(negedge clk);
    hw_req[b] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hw_req[b] = 1'b0;
  endtask

  task automatic serve(input logic [31:0] rb, input logic [31:0] wb,
                       input logic [3:0] step, input int n, input int gap,
                       input logic lck, input string tag);
    int got = 0;
    int idle = 0;
    int t = 0;
    mem_ready = 1'b1;
    while (got < n && t < 300) begin
      if (mem_valid) begin
        chk(mem_rd_addr == rb + got * step, {tag, " R8 rd addr"}, mem_rd_addr, rb + got * step);
        chk(mem_wr_addr == wb + got * step, {tag, " R8 wr addr"}, mem_wr_addr, wb + got * step);
        chk(bus_lock == lck, {tag, " R10 lock"}, 32'(bus_lock), 32'(lck));
        if (got > 0) chk(idle == gap, {tag, " R6/R7 gap"}, idle, gap);
        idle = 0;
        got++;
      end else idle++;
      @(negedge clk);
      t++;
    end
    mem_ready = 1'b0;
    chk(got == n, {tag, " word count"}, got, n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_valid && !bus_lock && !done && !irq, "reset state", 
        {27'd0, busy, mem_valid, bus_lock, done, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R1 R4 R6 R7 R8 R10 R12
    for (int i = 0; i < 6; i++) begin
      write_ctrl(VECS[i].ctrl, VECS[i].sa, VECS[i].da, 16'(VECS[i].len));
      chk(busy == 1'b1, "R1 busy after accept", 32'(busy), 1);
      chk(done == 1'b0, "R12 done cleared on accept", 32'(done), 0);
      if (VECS[i].hwb == 4'hF)
        chk(mem_valid == 1'b1, "R4 software start", 32'(mem_valid), 1);
      else begin
        chk(mem_valid == 1'b0, "R5 hardware waits", 32'(mem_valid), 0);
        pulse(int'(VECS[i].hwb));
      end
      serve(VECS[i].sa, VECS[i].da, VECS[i].step, int'(VECS[i].len),
            int'(VECS[i].gap), VECS[i].lck, $sformatf("vec%0d", i));
      chk(done && !busy, "R12 done after last word", {30'd0, done, busy}, 32'd2);
    end

    // R2: priority zero
    write_ctrl(mk(13'h0, 1'b0, 3'd0, 1'b0, 3'b110, 2'd2, 1'b0), 32'h100, 32'h200, 16'd2);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_valid, "R2 prio zero ignored", {30'd0, busy, mem_valid}, 0);

    // R3: reserved kind and spare bit
    write_ctrl(mk(13'h0, 1'b0, 3'd1, 1'b0, 3'b011, 2'd2, 1'b0), 32'h100, 32'h200, 16'd2);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_valid, "R3 reserved kind 011", {30'd0, busy, mem_valid}, 0);
    write_ctrl(mk(13'h0, 1'b0, 3'd1, 1'b0, 3'b111, 2'd2, 1'b0), 32'h100, 32'h200, 16'd2);
    repeat (3) @(negedge clk);
    chk(!busy, "R3 reserved kind 111", 32'(busy), 0);
    write_ctrl(mk(13'h0, 1'b0, 3'd1, 1'b0, 3'b110, 2'd2, 1'b0) | 32'h4, 32'h100, 32'h200, 16'd2);
    repeat (3) @(negedge clk);
    chk(!busy, "R3 spare bit set", 32'(busy), 0);

    // R5 R7 R13: hardware arbitrated, unselected line, write while waiting
    write_ctrl(mk(13'h0008, 1'b0, 3'd6, 1'b1, 3'b001, 2'd2, 1'b0), 32'h7000, 32'hE000, 16'd3);
    pulse(5);
    repeat (6) @(negedge clk);
    chk(busy && !mem_valid, "R5 unselected line ignored", {30'd0, busy, mem_valid}, 32'd2);
    write_ctrl(mk(13'h0, 1'b0, 3'd7, 1'b0, 3'b110, 2'd0, 1'b0), 32'h1, 32'h2, 16'd5);
    repeat (4) @(negedge clk);
    chk(!mem_valid, "R13 write while busy ignored", 32'(mem_valid), 0);
    chk(mem_rd_addr == 32'h7000, "R13 address kept", mem_rd_addr, 32'h7000);
    for (int w = 0; w < 3; w++) begin
      pulse(3);
      serve(32'h7000 + w * 4, 32'hE000 + w * 4, 4'd4, 1, 0, 1'b1, "R7 hw arb");
      repeat (4) @(negedge clk);
      if (w < 2) chk(!mem_valid && busy, "R7 needs new request", {30'd0, mem_valid, busy}, 32'd1);
    end
    chk(done && !busy, "R12 hw arb done", {30'd0, done, busy}, 32'd2);

    // R9: continue versus fresh start
    write_ctrl(mk(13'h0, 1'b0, 3'd1, 1'b0, 3'b110, 2'd2, 1'b0), 32'h1000, 32'h2000, 16'd2);
    serve(32'h1000, 32'h2000, 4'd4, 2, 0, 1'b0, "R9 first");
    write_ctrl(mk(13'h0, 1'b1, 3'd1, 1'b0, 3'b110, 2'd2, 1'b0), 32'h9000, 32'h9800, 16'd3);
    serve(32'h1008, 32'h2008, 4'd4, 3, 0, 1'b0, "R9 continue");
    write_ctrl(mk(13'h0, 1'b0, 3'd1, 1'b0, 3'b110, 2'd2, 1'b0), 32'h9000, 32'h9800, 16'd1);
    serve(32'h9000, 32'h9800, 4'd4, 1, 0, 1'b0, "R9 fresh");

    // R11: stall holds the word
    write_ctrl(mk(13'h0, 1'b0, 3'd2, 1'b1, 3'b000, 2'd2, 1'b0), 32'h3000, 32'h3800, 16'd2);
    for (int s = 0; s < 3; s++) begin
      chk(mem_valid && bus_lock, "R11 valid held", {30'd0, mem_valid, bus_lock}, 32'd3);
      chk(mem_rd_addr == 32'h3000 && mem_wr_addr == 32'h3800, "R11 addr held",
          mem_rd_addr, 32'h3000);
      @(negedge clk);
    end
    serve(32'h3000, 32'h3800, 4'd4, 2, 1, 1'b1, "R11 release");

    // R12: irq enable, and zero length
    begin
      int c0;
      c0 = irq_cnt;
      write_ctrl(mk(13'h0, 1'b0, 3'd1, 1'b0, 3'b110, 2'd2, 1'b1), 32'h0, 32'h40, 16'd1);
      serve(32'h0, 32'h40, 4'd4, 1, 0, 1'b0, "R12 irq on");
      repeat (2) @(negedge clk);
      chk(irq_cnt - c0 == 1, "R12 irq pulse", irq_cnt - c0, 1);
      c0 = irq_cnt;
      write_ctrl(mk(13'h0, 1'b0, 3'd1, 1'b0, 3'b110, 2'd2, 1'b0), 32'h0, 32'h40, 16'd1);
      serve(32'h0, 32'h40, 4'd4, 1, 0, 1'b0, "R12 irq off");
      repeat (2) @(negedge clk);
      chk(irq_cnt == c0, "R12 irq masked", irq_cnt - c0, 0);
      c0 = irq_cnt;
      write_ctrl(mk(13'h0, 1'b0, 3'd1, 1'b0, 3'b110, 2'd2, 1'b1), 32'h0, 32'h40, 16'd0);
      chk(done && !busy && !mem_valid, "R12 zero length",
          {29'd0, done, busy, mem_valid}, 32'd4);
      repeat (2) @(negedge clk);
      chk(irq_cnt - c0 == 1, "R12 zero length irq", irq_cnt - c0, 1);
    end

    summary();
  end

endmodule